// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block runs the acquisition side of a small logic analyzer. It owns a circular sample buffer that is 8 bits wide and 1024 entries deep. It makes the sample strobe from one of two sources: an internal clock divider, or an external sample pin that is synchronized and watched for a chosen edge. When a run is requested, the block first writes a counting pattern into every buffer location. It then records samples circularly until the capture-start input fires. After that it records a programmed number of further samples and streams the whole buffer out through a byte valid/ready port.

The counting pattern makes an early trigger easy to see: any location not overwritten by real samples still holds its index modulo 256. A test mode replaces the probe inputs with an incrementing counter. A status LED output follows the phase of the capture. Command decoding and trigger matching belong to neighbouring blocks; this block sees only the resulting strobes and settings.

Top module: `la_capture_ctrl`

## Requirements
- R1: After a capture, exactly 1024 bytes are delivered on the output port. While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_data_o` does not change. Bytes are offered only while the LED is lit.
- R2: After `run_i`, location i of the buffer is written with i modulo 256, one location per clock, before any sample is stored. Locations that no sample overwrites are sent with that value.
- R3: With `test_mode_i` high, the stored sample value is a count of the samples accepted since `run_i`. The count starts at 0 and wraps modulo 256.
- R4: With `use_ext_i` low, the block takes one sample every `div_i`+1 clocks while it is waiting for or after the trigger.
- R5: With `use_ext_i` high, `ext_pin_i` passes through two synchronizing flip-flops. One sample is taken per rising edge, or per falling edge when `ext_fall_i` is 1.
- R6: After the trigger, exactly `post_cnt_i` samples (latched at run, clamped to 1024) are stored before sending begins. A count of 0 starts sending at once. The pre-trigger portion counts as full after 1024 minus that many samples, and it is full at once when the count is 1024.
- R7: With `newest_first_i` latched at 0, sending begins at the oldest location (the next write position) and ascends. With 1, it begins at the newest sample and descends.
- R8: The LED is off in idle. It is on during prefill, during pre-trigger capture, during post-trigger capture and while sending. Once the pre-trigger portion is full, it toggles on every accepted sample until the trigger arrives.
- R9: `abort_i` returns the block to idle from any state. On the next clock the LED is off and `tx_valid_o` is low.
- R10: `run_i` is ignored unless the block is idle. `trig_i` is ignored except during pre-trigger capture (before or after the pre-trigger portion is full).
- R11: After synchronous reset the block is idle, the LED is off and `tx_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Start strobe, accepted in idle |
| abort_i | input | 1 | Return-to-idle strobe |
| trig_i | input | 1 | Capture-start strobe from the trigger logic |
| probe_i | input | 8 | Probe data |
| test_mode_i | input | 1 | Store the sample counter instead of probe data |
| use_ext_i | input | 1 | 1 selects the external sample pin |
| ext_fall_i | input | 1 | 1 selects the falling edge of the external pin |
| ext_pin_i | input | 1 | External sample clock pin (asynchronous) |
| div_i | input | 16 | Internal divider; period is div_i+1 clocks |
| post_cnt_i | input | 11 | Post-trigger sample count, latched at run |
| newest_first_i | input | 1 | Send order select, latched at run |
| tx_data_o | output | 8 | Output byte |
| tx_valid_o | output | 1 | Output byte valid |
| tx_ready_i | input | 1 | Sink ready |
| led_o | output | 1 | Status LED |

## Verification
Every cycle, the assertions check the output handshake: data holds under backpressure, no more than 1024 bytes go out per capture, and bytes appear only while the LED is lit. They also check the idle outputs after reset and after an abort. The contents and order of the streamed buffer cannot be expressed as a local property, and only the bench's scenarios show them. Those scenarios cover prefill values left behind by an early trigger, counter data in both send orders, divider and edge-selected sampling, and the post-count extremes of 0 and 1024. The bench compares all of these against its reference model clock by clock.

// File: rtl/la_capture_pkg.sv
package la_capture_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_PREFILL = 3'd1,
    ST_PRE     = 3'd2,
    ST_FULL    = 3'd3,
    ST_POST    = 3'd4,
    ST_SEND    = 3'd5
  } cap_state_e;
endpackage

// File: rtl/la_strobe_gen.sv
module la_strobe_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             use_ext,
  input  logic             ext_fall,
  input  logic             pin,
  input  logic [DIV_W-1:0] div,
  output logic             strobe_o
);
  logic             sync1, sync2, sync3;
  logic [DIV_W-1:0] cnt;
  logic             edge_hit;

  // sync2 is the second synchronizer stage; sync3 holds its previous value
  assign edge_hit = ext_fall ? (sync3 & ~sync2) : (sync2 & ~sync3);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1    <= 1'b0;
      sync2    <= 1'b0;
      sync3    <= 1'b0;
      cnt      <= '0;
      strobe_o <= 1'b0;
    end else begin
      sync1 <= pin;
      sync2 <= sync1;
      sync3 <= sync2;
      if (!en || cnt == div) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
      strobe_o <= en & (use_ext ? edge_hit : (cnt == div));
    end
  end
endmodule

// File: rtl/la_sample_ram.sv
module la_sample_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/la_capture_ctrl.sv
module la_capture_ctrl
  import la_capture_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  parameter int DIV_W  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_i,
  input  logic              abort_i,
  input  logic              trig_i,
  input  logic [DATA_W-1:0] probe_i,
  input  logic              test_mode_i,
  input  logic              use_ext_i,
  input  logic              ext_fall_i,
  input  logic              ext_pin_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [CW-1:0]     post_cnt_i,
  input  logic              newest_first_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              led_o
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  cap_state_e        st;
  logic [AW-1:0]     wp, rp, wp_nx, send_start;
  logic [CW-1:0]     fill, remain, issued, post_q;
  logic [DATA_W-1:0] tcnt, wdata;
  logic              newest_q, strobe, armed, take, we, load;

  assign armed      = (st == ST_PRE) || (st == ST_FULL) || (st == ST_POST);
  assign take       = armed && strobe;
  assign we         = (st == ST_PREFILL) || take;
  assign wdata      = (st == ST_PREFILL) ? DATA_W'(wp)
                    : (test_mode_i ? tcnt : probe_i);
  assign wp_nx      = we ? wp + 1'b1 : wp;
  assign send_start = newest_q ? wp_nx - 1'b1 : wp_nx;
  assign load       = (st == ST_SEND) && (issued != DEPTH_C) && (!tx_valid_o || tx_ready_i);

  la_strobe_gen #(.DIV_W(DIV_W)) u_strobe (
    .clk(clk), .rst(rst), .en(armed), .use_ext(use_ext_i), .ext_fall(ext_fall_i),
    .pin(ext_pin_i), .div(div_i), .strobe_o(strobe)
  );

  la_sample_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(wp), .wdata(wdata),
    .re(load), .raddr(rp), .rdata(tx_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      wp         <= '0;
      rp         <= '0;
      fill       <= '0;
      remain     <= '0;
      issued     <= '0;
      post_q     <= '0;
      tcnt       <= '0;
      newest_q   <= 1'b0;
      tx_valid_o <= 1'b0;
      led_o      <= 1'b0;
    end else if (abort_i) begin
      st         <= ST_IDLE;
      tx_valid_o <= 1'b0;
      led_o      <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (run_i) begin
          st       <= ST_PREFILL;
          wp       <= '0;
          tcnt     <= '0;
          post_q   <= (post_cnt_i > DEPTH_C) ? DEPTH_C : post_cnt_i;
          newest_q <= newest_first_i;
          led_o    <= 1'b1;
        end
        ST_PREFILL: begin
          wp <= wp_nx;
          if (wp == AW'(DEPTH - 1)) begin
            fill <= '0;
            st   <= (post_q == DEPTH_C) ? ST_FULL : ST_PRE;
          end
        end
        ST_PRE, ST_FULL: begin
          if (take) begin
            wp   <= wp_nx;
            tcnt <= tcnt + 1'b1;
            fill <= fill + 1'b1;
            if (st == ST_FULL) led_o <= ~led_o;
          end
          if (trig_i) begin
            led_o  <= 1'b1;
            remain <= post_q;
            if (post_q == '0) begin
              st     <= ST_SEND;
              rp     <= send_start;
              issued <= '0;
            end else begin
              st <= ST_POST;
            end
          end else if (st == ST_PRE && take && (fill + 1'b1 == DEPTH_C - post_q)) begin
            st <= ST_FULL;
          end
        end
        ST_POST: if (take) begin
          wp     <= wp_nx;
          tcnt   <= tcnt + 1'b1;
          remain <= remain - 1'b1;
          if (remain == CW'(1)) begin
            st     <= ST_SEND;
            rp     <= send_start;
            issued <= '0;
          end
        end
        ST_SEND: begin
          if (load) begin
            rp         <= newest_q ? rp - 1'b1 : rp + 1'b1;
            issued     <= issued + 1'b1;
            tx_valid_o <= 1'b1;
          end else if (tx_ready_i) begin
            tx_valid_o <= 1'b0;
          end
          if (issued == DEPTH_C && tx_valid_o && tx_ready_i) begin
            st         <= ST_IDLE;
            led_o      <= 1'b0;
            tx_valid_o <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/la_capture_chk.sv
module la_capture_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input logic              clk,
  input logic              rst,
  input logic              abort_i,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic              led_o
);
  int unsigned hs_cnt;

  always_ff @(posedge clk) begin
    if (rst || !led_o) hs_cnt <= 0;
    else if (tx_valid_o && tx_ready_i) hs_cnt <= hs_cnt + 1;
  end

  // R11: reset leaves the outputs idle
  a_r11_reset_idle: assert property (@(posedge clk) rst |=> (!tx_valid_o && !led_o));

  // R9: abort forces idle outputs on the next clock
  a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst) abort_i |=> (!tx_valid_o && !led_o));

  // R1: a stalled byte is held unchanged
  a_r1_hold_stall: assert property (@(posedge clk) disable iff (rst || abort_i)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  // R1: bytes are offered only while the LED is lit
  a_r1_valid_lit: assert property (@(posedge clk) disable iff (rst) tx_valid_o |-> led_o);

  // R1: no more than DEPTH bytes per capture
  a_r1_no_excess: assert property (@(posedge clk) disable iff (rst) hs_cnt <= DEPTH);
endmodule

bind la_capture_ctrl la_capture_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .abort_i(abort_i), .tx_data_o(tx_data_o),
  .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i), .led_o(led_o)
);

// File: tb/la_capture_ctrl_test.sv
module la_capture_ctrl_test;
  localparam int DEPTH = 1024;

  logic       clk = 0, rst = 1, run = 0, abort = 0, trig = 0;
  logic [7:0] probe = 0;
  logic       tmode = 0, use_ext = 0, ext_fall = 0, ext_pin = 0, newest = 0, ready = 1;
  logic [15:0] div = 0;
  logic [10:0] post = 0;
  logic [7:0] txd;
  logic       txv, led;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  int ready_mode = 0, pin_mode = 0, probe_mode = 0, pin_ctr = 0;
  string cur_req = "R2";
  byte unsigned rx[$];

  la_capture_ctrl uut (
    .clk(clk), .rst(rst), .run_i(run), .abort_i(abort), .trig_i(trig),
    .probe_i(probe), .test_mode_i(tmode), .use_ext_i(use_ext), .ext_fall_i(ext_fall),
    .ext_pin_i(ext_pin), .div_i(div), .post_cnt_i(post), .newest_first_i(newest),
    .tx_data_o(txd), .tx_valid_o(txv), .tx_ready_i(ready), .led_o(led)
  );

  always #4 clk = ~clk;

  // ---------------- reference model ----------------
  int ms = 0, m_wp = 0, m_rp = 0, m_fill = 0, m_rem = 0, m_iss = 0, m_post = 0, m_tc = 0;
  int m_cnt = 0;
  bit m_new = 0, m_txv = 0, m_led = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0, m_stb = 0;
  int m_txd = 0;
  int mm [DEPTH];

  always @(posedge clk) begin
    automatic bit en_o = (ms == 2 || ms == 3 || ms == 4);
    automatic bit tk = en_o && m_stb;
    automatic bit edg = ext_fall ? (m_s3 && !m_s2) : (m_s2 && !m_s3);
    automatic bit nstb = en_o && (use_ext ? edg : (m_cnt == int'(div)));
    automatic int ncnt = (!en_o || m_cnt == int'(div)) ? 0 : m_cnt + 1;
    automatic int sval = tmode ? m_tc : int'(probe);
    automatic int wpn = m_wp;
    automatic bit ld;
    if (rst) begin
      ms = 0; m_txv = 0; m_led = 0; m_wp = 0; m_tc = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_stb = 0;
    end else begin
      if (abort) begin
        ms = 0; m_txv = 0; m_led = 0;
      end else begin
        case (ms)
          0: if (run) begin
            ms = 1; m_wp = 0; m_tc = 0; m_led = 1; m_new = newest;
            m_post = (int'(post) > DEPTH) ? DEPTH : int'(post);
          end
          1: begin
            mm[m_wp] = m_wp % 256;
            m_wp = m_wp + 1;
            if (m_wp == DEPTH) begin
              m_wp = 0; m_fill = 0; ms = (m_post == DEPTH) ? 3 : 2;
            end
          end
          2, 3: begin
            automatic int old = ms;
            if (tk) begin
              mm[m_wp] = sval; m_wp = (m_wp + 1) % DEPTH; m_tc = (m_tc + 1) % 256;
              m_fill++;
              if (old == 3) m_led = !m_led;
            end
            if (trig) begin
              m_led = 1; m_rem = m_post;
              if (m_post == 0) begin
                ms = 5; m_iss = 0; m_rp = m_new ? (m_wp + DEPTH - 1) % DEPTH : m_wp;
              end else ms = 4;
            end else if (old == 2 && tk && m_fill == DEPTH - m_post) ms = 3;
          end
          4: if (tk) begin
            mm[m_wp] = sval; m_wp = (m_wp + 1) % DEPTH; m_tc = (m_tc + 1) % 256;
            m_rem--;
            if (m_rem == 0) begin
              ms = 5; m_iss = 0; m_rp = m_new ? (m_wp + DEPTH - 1) % DEPTH : m_wp;
            end
          end
          5: begin
            automatic bit done = (m_iss == DEPTH) && m_txv && ready;
            ld = (m_iss != DEPTH) && (!m_txv || ready);
            if (ld) begin
              m_txd = mm[m_rp]; m_txv = 1; m_iss++;
              m_rp = m_new ? (m_rp + DEPTH - 1) % DEPTH : (m_rp + 1) % DEPTH;
            end else if (ready) m_txv = 0;
            if (done) begin ms = 0; m_led = 0; m_txv = 0; end
          end
          default: ms = 0;
        endcase
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin; m_cnt = ncnt; m_stb = nstb;
    end
    if (wpn < 0) m_wp = 0;
  end

  // capture handshakes as the design presents them
  always @(posedge clk) if (!rst && !abort && txv && ready) rx.push_back(txd);

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    #2;
    cycles++;
    if (!rst) begin
      n_cmp++;
      if (txv !== m_txv) begin
        n_bad++; $display("FAIL R1 tx_valid actual=%0b expected=%0b t=%0t", txv, m_txv, $time);
      end
      if (led !== m_led) begin
        n_bad++; $display("FAIL R8 led actual=%0b expected=%0b t=%0t", led, m_led, $time);
      end
      if (m_txv && txd !== 8'(m_txd)) begin
        n_bad++; $display("FAIL %s data actual=%0h expected=%0h t=%0t", cur_req, txd, m_txd, $time);
      end
    end
  end

  // background stimulus
  always @(negedge clk) begin
    ready = (ready_mode != 0) ? ($urandom % 3 != 0) : 1'b1;
    if (pin_mode != 0) begin
      pin_ctr++;
      if (pin_ctr >= 3) begin pin_ctr = 0; ext_pin = !ext_pin; end
    end
    if (probe_mode != 0) probe = probe + 8'd7;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++; $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_run();
    rx.delete();
    @(negedge clk) run = 1;
    @(negedge clk) run = 0;
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
  endtask

  task automatic wait_state(input int s);
    while (ms != s) @(negedge clk);
  endtask

  task automatic finish_run();
    @(negedge clk);
    wait_state(0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: reset state
    check(led == 0 && txv == 0, "R11 reset idle", {led, txv}, 0);

    // R3 + R7: test counter, divider every clock, full pre, oldest first
    tmode = 1; div = 0; post = 100; newest = 0; cur_req = "R3";
    pulse_run();
    pulse_trig(); // R10: trigger during prefill is ignored
    check(led == 1 && ms == 1, "R10 trig ignored in prefill", ms, 1);
    wait_state(3);
    repeat (20) @(negedge clk);
    pulse_trig();
    finish_run();
    check(rx.size() == DEPTH, "R1 byte count", rx.size(), DEPTH);
    begin
      automatic int bad = 0;
      for (int i = 0; i + 1 < rx.size(); i++) if (rx[i+1] != 8'(rx[i] + 1)) bad++;
      check(bad == 0, "R3 ascending counter oldest-first", bad, 0);
    end

    // R2: early trigger leaves prefill pattern, probe constant
    tmode = 0; probe = 8'hA5; div = 3; post = 4; cur_req = "R2";
    pulse_run();
    wait_state(2);
    repeat (12) @(negedge clk);
    pulse_trig();
    finish_run();
    check(rx.size() == DEPTH, "R1 byte count", rx.size(), DEPTH);
    begin
      automatic int a5 = 0;
      foreach (rx[i]) if (rx[i] == 8'hA5) a5++;
      check(a5 > 4 && a5 < 20, "R2 real samples few", a5, 8);
      check(rx.size() > 1 && rx[1] == 8'(rx[0] + 1), "R2 prefill pattern", rx[1], rx[0] + 1);
    end

    // R4 + R8: divider period via LED toggles in full state
    tmode = 1; div = 4; post = 1000; cur_req = "R4";
    pulse_run();
    wait_state(3);
    repeat (3) @(negedge clk);
    begin
      automatic int tg = 0;
      automatic logic prev = led;
      for (int i = 0; i < 50; i++) begin
        @(negedge clk);
        if (led != prev) tg++;
        prev = led;
      end
      check(tg == 10, "R4 R8 toggles per 50 clocks", tg, 10);
    end
    pulse_run(); // R10: run ignored during capture
    check(ms == 3, "R10 run ignored", ms, 3);
    pulse_trig();
    ready_mode = 1;
    finish_run();
    ready_mode = 0;
    check(rx.size() == DEPTH, "R1 byte count under backpressure", rx.size(), DEPTH);

    // R5 + R7: external rising edge, newest first, test data
    use_ext = 1; ext_fall = 0; pin_mode = 1; newest = 1; post = 50; cur_req = "R5";
    pulse_run();
    wait_state(3);
    pulse_trig();
    finish_run();
    check(rx.size() == DEPTH, "R1 byte count", rx.size(), DEPTH);
    begin
      automatic int bad = 0;
      for (int i = 0; i + 1 < rx.size(); i++) if (rx[i+1] != 8'(rx[i] - 1)) bad++;
      check(bad == 0, "R7 descending newest-first", bad, 0);
    end

    // R5: external falling edge, walking probe data
    ext_fall = 1; tmode = 0; probe_mode = 1; newest = 0; post = 300;
    pulse_run();
    wait_state(3);
    pulse_trig();
    finish_run();
    check(rx.size() == DEPTH, "R1 byte count falling edge", rx.size(), DEPTH);
    use_ext = 0; pin_mode = 0; probe_mode = 0;

    // R6: post count zero, send immediately
    tmode = 1; div = 1; post = 0; cur_req = "R6";
    pulse_run();
    wait_state(3);
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
    check(ms == 5, "R6 zero post goes to send", ms, 5);
    finish_run();
    check(rx.size() == DEPTH, "R1 byte count post 0", rx.size(), DEPTH);

    // R6: post count 1024, pre depth zero -> full straight after prefill
    div = 0; post = 11'd1024;
    pulse_run();
    wait_state(3);
    check(m_fill == 0, "R6 full with no pre samples", m_fill, 0);
    pulse_trig();
    finish_run();
    check(rx.size() == DEPTH, "R1 byte count post 1024", rx.size(), DEPTH);
    begin
      automatic int bad = 0;
      for (int i = 0; i + 1 < rx.size(); i++) if (rx[i+1] != 8'(rx[i] + 1)) bad++;
      check(bad == 0, "R6 all post samples consecutive", bad, 0);
    end

    // R9: abort during send and during pre capture
    post = 10; cur_req = "R9";
    pulse_run();
    wait_state(3);
    pulse_trig();
    wait_state(5);
    repeat (30) @(negedge clk);
    @(negedge clk) abort = 1;
    @(negedge clk) abort = 0;
    check(led == 0 && txv == 0, "R9 abort in send", {led, txv}, 0);
    check(rx.size() < DEPTH, "R9 send cut short", rx.size(), 0);
    pulse_run();
    wait_state(2);
    @(negedge clk) abort = 1;
    @(negedge clk) abort = 0;
    check(led == 0 && ms == 0, "R9 abort in pre", led, 0);
    repeat (10) @(negedge clk);
    check(txv == 0, "R9 stays idle", txv, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    while (cycles < 190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule